// File: doc/BRIEF.md
# Dual-Channel Indirect Register Access Front End

This block sits between an 8-bit host bus and a two-channel serial controller. Each channel exposes only one control port. The host reaches any of sixteen registers with a two-step protocol. The first write to the port selects a register number, and it can also carry a command code and a reset code in the same byte. The access after that reads or writes the selected register, and the channel's pointer then falls back to register 0. The serial engines, the baud generator and the interrupt logic live outside this block. They see the write registers as flat output vectors, they drive their status bytes in as flat input vectors, and they receive decoded commands as one-cycle pulses.

Each channel runs a pointer state machine with two states, `PTR_ZERO` and `PTR_ARMED`.
- **PTR_ZERO → PTR_ARMED**: a control write whose target register is not 0.
- **PTR_ZERO → PTR_ZERO**: a control write whose target is 0 (a pure command byte), or a read. A read in this state returns status register 0.
- **PTR_ARMED → PTR_ZERO**: any read or write on that channel. The access uses the latched register number.

Two register slots, the interrupt vector (2) and the master control (9), are a single storage element shared by both channels. Some read slots differ between the two channels.

Top module: `dual_ser_regfront`

## Requirements
- R1: Hardware reset clears every write register output to 0, clears both channel pointers to register 0, and leaves all command pulse outputs low.
- R2: A write in `PTR_ZERO` selects register `{cmd==1, byte[2:0]}`. If that register is not 0, the next write on that channel stores its byte into that write register, and the new value appears on the channel's write-register output vector (slot k at bits 8k+7:8k) after the edge that accepts the write.
- R3: A read is answered on `bus_rdata_o`, with `bus_rvalid_o` high, in the cycle after the read is accepted. A read in `PTR_ARMED` returns the selected read register. A read register with no special rule returns the channel's status input byte for that slot.
- R4: After any data access to a selected register, the pointer returns to 0. The next access on that channel then targets register 0: a read returns status byte 0.
- R5: A write in `PTR_ZERO` fires a command pulse for one cycle, in the cycle after the write, on bit (c−2) of the channel's command output, for each command field value c = byte[5:3] from 2 to 7. The values are: 2 reset external status, 3 send abort, 4 arm interrupt on next received character, 5 clear transmit pending, 6 clear error, 7 clear highest in-service.
- R6: The reset field r = byte[7:6] fires a pulse on bit 5+r of the command output: r=1 receive CRC reset, r=2 transmit CRC reset, r=3 transmit underrun/end-of-message latch reset. It can fire in the same cycle as a command pulse.
- R7: Registers 8 to 15 are reached only with command field value 1 (point high), which adds 8 to byte[2:0] and fires no pulse. A byte of 0x04 selects register 4, not register 12.
- R8: Write registers 2 and 9 are shared. A write through either channel updates the slot on both channels' output vectors.
- R9: Read register 3 returns channel A's status byte 3 on channel A and always returns 0x00 on channel B.
- R10: Read register 2 returns the shared vector register on channel A and channel B's status byte 2 on channel B.
- R11: Read register 15 returns write register 15 ANDed with 0xFA. Read registers 12 and 13 return the channel's own write registers 12 and 13.
- R12: The two channels' pointers are independent. Accesses on one channel neither move nor consume the other channel's pointer, and command pulses appear only on the addressed channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| bus_en_i | input | 1 | Bus access strobe, one access per cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_ch_i | input | 1 | Channel select: 0 = A, 1 = B |
| bus_wdata_i | input | 8 | Write byte (pointer/command byte or register data) |
| bus_rdata_o | output | 8 | Read byte, registered |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after a read |
| stat_a_i | input | 128 | Channel A status bytes, slot k at bits 8k+7:8k |
| stat_b_i | input | 128 | Channel B status bytes, slot k at bits 8k+7:8k |
| wreg_a_o | output | 128 | Channel A write registers, slot k at bits 8k+7:8k |
| wreg_b_o | output | 128 | Channel B write registers, slot k at bits 8k+7:8k |
| cmd_a_o | output | 9 | Channel A command/reset pulses |
| cmd_b_o | output | 9 | Channel B command/reset pulses |

## Verification
The bench goes after the pointer falling back to 0. A design that kept the pointer armed would answer a later plain read with a stale register instead of status byte 0. The point-high path is exercised with bytes that differ only in bit 3. A design that ignored point high, or added 8 without it, would write slot 4 and slot 12 interchangeably. The bench also probes the shared and asymmetric slots:
- a per-channel copy of register 2 or 9 would show a mismatch between the two output vectors;
- a missing channel-B rule would leak status byte 3 or the vector register;
- an unmasked register 15 readback would return 0xFF instead of 0xFA.

It also checks that a combined command-and-reset byte fires both pulses for exactly one cycle, and that arming one channel leaves the other at register 0.

// File: rtl/srf_pkg.sv
package srf_pkg;

    localparam int BYTE_W   = 8;
    localparam int NUM_CMD  = 9;

    localparam int SLOT_VEC   = 2;
    localparam int SLOT_MIC   = 9;
    localparam int SLOT_IPEND = 3;
    localparam int SLOT_IECTL = 15;
    localparam int SLOT_BRLO  = 12;
    localparam int SLOT_BRHI  = 13;
    localparam logic [BYTE_W-1:0] IECTL_RD_MASK = 8'hFA;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_POINT_HI = 3'd1,
        CMD_RST_EXT  = 3'd2,
        CMD_ABORT    = 3'd3,
        CMD_ARM_RX   = 3'd4,
        CMD_CLR_TXP  = 3'd5,
        CMD_CLR_ERR  = 3'd6,
        CMD_CLR_IUS  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        RST_NONE   = 2'd0,
        RST_RX_CRC = 2'd1,
        RST_TX_CRC = 2'd2,
        RST_TX_EOM = 2'd3
    } rst_e;

    typedef enum logic {
        PTR_ZERO  = 1'b0,
        PTR_ARMED = 1'b1
    } ptr_state_e;

    function automatic logic [3:0] target_of(input logic [BYTE_W-1:0] b);
        return {(cmd_e'(b[5:3]) == CMD_POINT_HI), b[2:0]};
    endfunction

endpackage

// File: rtl/srf_ptr_fsm.sv
module srf_ptr_fsm
    import srf_pkg::*;
#(
    parameter int IDXW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              we_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic [IDXW-1:0]   sel_o,
    output logic              reg_wr_o,
    output logic              cmd_fire_o
);

    ptr_state_e          state_q, state_d;
    logic [IDXW-1:0]     ptr_q, ptr_d;
    logic [IDXW-1:0]     target;

    assign target = IDXW'(target_of(byte_i));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PTR_ZERO;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            PTR_ZERO: begin
                if (acc_i && we_i && (target != '0)) begin
                    state_d = PTR_ARMED;
                    ptr_d   = target;
                end
            end
            PTR_ARMED: begin
                if (acc_i) begin
                    state_d = PTR_ZERO;
                    ptr_d   = '0;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        sel_o      = '0;
        reg_wr_o   = 1'b0;
        cmd_fire_o = 1'b0;
        unique case (state_q)
            PTR_ZERO: begin
                cmd_fire_o = acc_i && we_i;
            end
            PTR_ARMED: begin
                sel_o    = ptr_q;
                reg_wr_o = acc_i && we_i;
            end
        endcase
    end

endmodule

// File: rtl/srf_cmd_decode.sv
module srf_cmd_decode
    import srf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire_i,
    input  logic [BYTE_W-1:0]  byte_i,
    output logic [NUM_CMD-1:0] pulse_o
);

    logic [NUM_CMD-1:0] hit;

    always_comb begin
        hit = '0;
        if (fire_i) begin
            unique case (cmd_e'(byte_i[5:3]))
                CMD_NONE,
                CMD_POINT_HI: ;
                CMD_RST_EXT:  hit[0] = 1'b1;
                CMD_ABORT:    hit[1] = 1'b1;
                CMD_ARM_RX:   hit[2] = 1'b1;
                CMD_CLR_TXP:  hit[3] = 1'b1;
                CMD_CLR_ERR:  hit[4] = 1'b1;
                CMD_CLR_IUS:  hit[5] = 1'b1;
            endcase
            unique case (rst_e'(byte_i[7:6]))
                RST_NONE:   ;
                RST_RX_CRC: hit[6] = 1'b1;
                RST_TX_CRC: hit[7] = 1'b1;
                RST_TX_EOM: hit[8] = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_o <= '0;
        else        pulse_o <= hit;
    end

endmodule

// File: rtl/srf_wreg_file.sv
module srf_wreg_file
    import srf_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           we_i,
    input  logic [IDXW-1:0]      sel_i [2],
    input  logic [DW-1:0]        wdata_i,
    output logic [NREG*DW-1:0]   wreg_o [2]
);

    logic [DW-1:0] shared_q [2];
    logic [DW-1:0] slot     [2][NREG];

    for (genvar s = 0; s < 2; s++) begin : g_shared
        localparam int IDX = (s == 0) ? SLOT_VEC : SLOT_MIC;
        logic hit;
        assign hit = (we_i[0] && sel_i[0] == IDXW'(IDX)) ||
                     (we_i[1] && sel_i[1] == IDXW'(IDX));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   shared_q[s] <= '0;
            else if (hit) shared_q[s] <= wdata_i;
        end
    end

    for (genvar c = 0; c < 2; c++) begin : g_chan
        for (genvar r = 0; r < NREG; r++) begin : g_reg
            if (r == 0) begin : g_cmd
                assign slot[c][r] = '0;
            end else if (r == SLOT_VEC) begin : g_vec
                assign slot[c][r] = shared_q[0];
            end else if (r == SLOT_MIC) begin : g_mic
                assign slot[c][r] = shared_q[1];
            end else begin : g_priv
                logic [DW-1:0] q;
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        q <= '0;
                    else if (we_i[c] && sel_i[c] == IDXW'(r))
                        q <= wdata_i;
                end
                assign slot[c][r] = q;
            end
            assign wreg_o[c][r*DW +: DW] = slot[c][r];
        end
    end

endmodule

// File: rtl/srf_read_mux.sv
module srf_read_mux
    import srf_pkg::*;
#(
    parameter int NREG      = 16,
    parameter int DW        = 8,
    parameter bit IS_CHAN_A = 1'b1,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic [IDXW-1:0]    sel_i,
    input  logic [NREG*DW-1:0] wreg_i,
    input  logic [NREG*DW-1:0] stat_i,
    output logic [DW-1:0]      rd_o
);

    logic [DW-1:0] vec_rd;
    logic [DW-1:0] ipend_rd;

    if (IS_CHAN_A) begin : g_chan_a
        assign vec_rd   = wreg_i[SLOT_VEC*DW +: DW];
        assign ipend_rd = stat_i[SLOT_IPEND*DW +: DW];
    end else begin : g_chan_b
        assign vec_rd   = stat_i[SLOT_VEC*DW +: DW];
        assign ipend_rd = '0;
    end

    always_comb begin
        case (int'(sel_i))
            SLOT_VEC:   rd_o = vec_rd;
            SLOT_IPEND: rd_o = ipend_rd;
            SLOT_IECTL: rd_o = wreg_i[SLOT_IECTL*DW +: DW] & DW'(IECTL_RD_MASK);
            SLOT_BRLO,
            SLOT_BRHI:  rd_o = wreg_i[sel_i*DW +: DW];
            default:    rd_o = stat_i[sel_i*DW +: DW];
        endcase
    end

endmodule

// File: rtl/dual_ser_regfront.sv
module dual_ser_regfront
    import srf_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en_i,
    input  logic                bus_we_i,
    input  logic                bus_ch_i,
    input  logic [DW-1:0]       bus_wdata_i,
    output logic [DW-1:0]       bus_rdata_o,
    output logic                bus_rvalid_o,
    input  logic [NREG*DW-1:0]  stat_a_i,
    input  logic [NREG*DW-1:0]  stat_b_i,
    output logic [NREG*DW-1:0]  wreg_a_o,
    output logic [NREG*DW-1:0]  wreg_b_o,
    output logic [NUM_CMD-1:0]  cmd_a_o,
    output logic [NUM_CMD-1:0]  cmd_b_o
);

    logic [1:0]           acc;
    logic [1:0]           reg_wr;
    logic [1:0]           fire;
    logic [IDXW-1:0]      sel   [2];
    logic [NREG*DW-1:0]   wreg  [2];
    logic [NREG*DW-1:0]   stat  [2];
    logic [DW-1:0]        rd    [2];
    logic [NUM_CMD-1:0]   pulse [2];

    assign stat[0] = stat_a_i;
    assign stat[1] = stat_b_i;

    for (genvar c = 0; c < 2; c++) begin : g_ch
        assign acc[c] = bus_en_i && (bus_ch_i == 1'(c));

        srf_ptr_fsm #(.IDXW(IDXW)) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .acc_i      (acc[c]),
            .we_i       (bus_we_i),
            .byte_i     (BYTE_W'(bus_wdata_i)),
            .sel_o      (sel[c]),
            .reg_wr_o   (reg_wr[c]),
            .cmd_fire_o (fire[c])
        );

        srf_cmd_decode u_dec (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire_i  (fire[c]),
            .byte_i  (BYTE_W'(bus_wdata_i)),
            .pulse_o (pulse[c])
        );

        srf_read_mux #(.NREG(NREG), .DW(DW), .IS_CHAN_A(c == 0)) u_rd (
            .sel_i  (sel[c]),
            .wreg_i (wreg[c]),
            .stat_i (stat[c]),
            .rd_o   (rd[c])
        );
    end

    srf_wreg_file #(.NREG(NREG), .DW(DW)) u_wregs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_wr),
        .sel_i   (sel),
        .wdata_i (bus_wdata_i),
        .wreg_o  (wreg)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata_o  <= '0;
            bus_rvalid_o <= 1'b0;
        end else begin
            bus_rvalid_o <= bus_en_i && !bus_we_i;
            if (bus_en_i && !bus_we_i)
                bus_rdata_o <= rd[bus_ch_i];
        end
    end

    assign wreg_a_o = wreg[0];
    assign wreg_b_o = wreg[1];
    assign cmd_a_o  = pulse[0];
    assign cmd_b_o  = pulse[1];

endmodule

// File: rtl/srf_chk.sv
module srf_chk
    import srf_pkg::*;
#(
    parameter int WV = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_en_i,
    input logic               bus_we_i,
    input logic               bus_ch_i,
    input logic               bus_rvalid_o,
    input logic [WV-1:0]      wreg_a_o,
    input logic [WV-1:0]      wreg_b_o,
    input logic [NUM_CMD-1:0] cmd_a_o,
    input logic [NUM_CMD-1:0] cmd_b_o
);

    // R3
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid_o |-> $past(bus_en_i && !bus_we_i));

    // R5
    cmd_a_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_a_o != '0) |-> $past(bus_en_i && bus_we_i && !bus_ch_i));

    // R12
    cmd_b_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_b_o != '0) |-> $past(bus_en_i && bus_we_i && bus_ch_i));

    // R2
    wreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_en_i && bus_we_i) |-> ($stable(wreg_a_o) && $stable(wreg_b_o)));

    // R6
    rst_field_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_a_o[8:6]) && $onehot0(cmd_b_o[8:6]));

endmodule

bind dual_ser_regfront srf_chk #(.WV(NREG*DW)) u_srf_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_en_i     (bus_en_i),
    .bus_we_i     (bus_we_i),
    .bus_ch_i     (bus_ch_i),
    .bus_rvalid_o (bus_rvalid_o),
    .wreg_a_o     (wreg_a_o),
    .wreg_b_o     (wreg_b_o),
    .cmd_a_o      (cmd_a_o),
    .cmd_b_o      (cmd_b_o)
);

// File: tb/tb_dual_ser_regfront.sv
`timescale 1ns/1ps
module tb_dual_ser_regfront;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_en = 1'b0, bus_we = 1'b0, bus_ch = 1'b0;
    logic [7:0]   bus_wdata = '0;
    logic [7:0]   bus_rdata;
    logic         bus_rvalid;
    logic [127:0] stat_a, stat_b, wreg_a, wreg_b;
    logic [8:0]   cmd_a, cmd_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_ser_regfront dut (
        .clk(clk), .rst_n(rst_n),
        .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_ch_i(bus_ch),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
        .stat_a_i(stat_a), .stat_b_i(stat_b),
        .wreg_a_o(wreg_a), .wreg_b_o(wreg_b),
        .cmd_a_o(cmd_a), .cmd_b_o(cmd_b)
    );

    initial begin
        for (int k = 0; k < 16; k++) begin
            stat_a[8*k +: 8] = 8'hA0 + 8'(k);
            stat_b[8*k +: 8] = 8'hB0 + 8'(k);
        end
    end

    // {ch, we, data, expected read, requirement number}
    localparam int NV = 31;
    localparam logic [21:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'h00, 8'hA0, 4'd1},  // R1 plain read hits status 0
        {1'b0, 1'b1, 8'h05, 8'h00, 4'd2},  // R2 select 5
        {1'b0, 1'b1, 8'h5A, 8'h00, 4'd2},  // R2 write WR5
        {1'b0, 1'b1, 8'h05, 8'h00, 4'd3},
        {1'b0, 1'b0, 8'h00, 8'hA5, 4'd3},  // R3 RR5 is status
        {1'b0, 1'b1, 8'h0C, 8'h00, 4'd7},  // R7 point high + 4
        {1'b0, 1'b1, 8'h34, 8'h00, 4'd7},
        {1'b0, 1'b1, 8'h0C, 8'h00, 4'd11},
        {1'b0, 1'b0, 8'h00, 8'h34, 4'd11}, // R11 RR12 = WR12
        {1'b0, 1'b1, 8'h0F, 8'h00, 4'd11},
        {1'b0, 1'b1, 8'hFF, 8'h00, 4'd11},
        {1'b0, 1'b1, 8'h0F, 8'h00, 4'd11},
        {1'b0, 1'b0, 8'h00, 8'hFA, 4'd11}, // R11 RR15 masked
        {1'b0, 1'b1, 8'h02, 8'h00, 4'd8},
        {1'b0, 1'b1, 8'h77, 8'h00, 4'd8},  // R8 shared vector write
        {1'b1, 1'b1, 8'h02, 8'h00, 4'd10},
        {1'b1, 1'b0, 8'h00, 8'hB2, 4'd10}, // R10 B RR2 is status
        {1'b0, 1'b1, 8'h02, 8'h00, 4'd10},
        {1'b0, 1'b0, 8'h00, 8'h77, 4'd10}, // R10 A RR2 is vector
        {1'b1, 1'b1, 8'h03, 8'h00, 4'd9},
        {1'b1, 1'b0, 8'h00, 8'h00, 4'd9},  // R9 B RR3 zero
        {1'b0, 1'b1, 8'h03, 8'h00, 4'd9},
        {1'b0, 1'b0, 8'h00, 8'hA3, 4'd9},  // R9 A RR3 status
        {1'b0, 1'b1, 8'h06, 8'h00, 4'd4},
        {1'b0, 1'b1, 8'h11, 8'h00, 4'd4},
        {1'b0, 1'b0, 8'h00, 8'hA0, 4'd4},  // R4 back to zero
        {1'b0, 1'b1, 8'h04, 8'h00, 4'd12}, // A armed on 4
        {1'b1, 1'b1, 8'h04, 8'h00, 4'd12},
        {1'b1, 1'b1, 8'h22, 8'h00, 4'd12},
        {1'b0, 1'b0, 8'h00, 8'hA4, 4'd12}, // R12 A still armed
        {1'b1, 1'b0, 8'h00, 8'hB0, 4'd4}   // R4 B back to zero
    };

    task automatic check(input logic [127:0] act, input logic [127:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic ch, input logic we, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = we; bus_ch = ch; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic pulse_test(input logic ch, input logic [7:0] d, input logic [8:0] exp, input string req);
        acc(ch, 1'b1, d);
        check(ch ? cmd_b : cmd_a, exp, req);
        check(ch ? cmd_a : cmd_b, 9'h0, "R12 other channel quiet");
        @(negedge clk);
        check({cmd_a, cmd_b}, 18'h0, {req, " single cycle"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(wreg_a, '0, "R1 wreg_a");
        check(wreg_b, '0, "R1 wreg_b");
        check({cmd_a, cmd_b, bus_rvalid}, '0, "R1 pulses");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][21], VEC[i][20], VEC[i][19:12]);
            if (!VEC[i][20]) begin
                check(bus_rvalid, 1'b1, $sformatf("R3 rvalid vec %0d", i));
                check(bus_rdata, VEC[i][11:4], $sformatf("R%0d vec %0d", VEC[i][3:0], i));
            end
        end

        check(wreg_a[5*8 +: 8],  8'h5A, "R2 WR5");
        check(wreg_a[6*8 +: 8],  8'h11, "R2 WR6");
        check(wreg_a[12*8 +: 8], 8'h34, "R7 WR12");
        check(wreg_a[4*8 +: 8],  8'h00, "R7 WR4 untouched");
        check(wreg_a[15*8 +: 8], 8'hFF, "R11 WR15 full");
        check(wreg_a[2*8 +: 8],  8'h77, "R8 A vec");
        check(wreg_b[2*8 +: 8],  8'h77, "R8 B vec");
        check(wreg_b[4*8 +: 8],  8'h22, "R12 B WR4");

        // R8 shared master control written through B
        acc(1'b1, 1'b1, 8'h09);
        acc(1'b1, 1'b1, 8'h3C);
        check(wreg_a[9*8 +: 8], 8'h3C, "R8 A mic");
        check(wreg_b[9*8 +: 8], 8'h3C, "R8 B mic");

        // R7 point high with register 0 selects 8, no pulse
        acc(1'b0, 1'b1, 8'h08);
        check(cmd_a, 9'h0, "R7 no pulse");
        acc(1'b0, 1'b1, 8'h5C);
        check(wreg_a[8*8 +: 8], 8'h5C, "R7 WR8");
        check(wreg_a[0*8 +: 8], 8'h00, "R7 WR0 slot");

        // R5 commands, R6 resets
        pulse_test(1'b0, 8'h10, 9'h001, "R5 reset ext");
        pulse_test(1'b1, 8'h18, 9'h002, "R5 abort");
        pulse_test(1'b1, 8'h20, 9'h004, "R5 arm rx");
        pulse_test(1'b0, 8'h38, 9'h020, "R5 clr ius");
        pulse_test(1'b1, 8'h30, 9'h010, "R5 clr err");
        pulse_test(1'b0, 8'hE8, 9'h108, "R6 eom + clr txp");
        pulse_test(1'b1, 8'h40, 9'h040, "R6 rx crc");
        pulse_test(1'b0, 8'h80, 9'h080, "R6 tx crc");

        // R1 mid-run reset clears armed pointer and registers
        acc(1'b0, 1'b1, 8'h05);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); check(wreg_a, '0, "R1 wreg_a after reset");
        check(wreg_b, '0, "R1 wreg_b after reset");
        rst_n = 1'b1;
        acc(1'b0, 1'b0, 8'h00);
        check(bus_rdata, 8'hA0, "R1 pointer cleared");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule